// File: doc/BRIEF.md
# Tile Primitive Binning Unit

This unit sorts a stream of screen-space triangles into per-tile lists. The render area is cut into square tiles whose edge is 16 or 32 pixels. Each incoming triangle has already been transformed and culled. The unit takes the integer bounding box of its three vertices and clamps that box to the render area. It then appends the triangle's identifier to the list of every tile the box touches. These lists have a fixed capacity and sit in an internal memory, with a fill count kept for each tile.

The unit works in two phases. In the binning phase it accepts triangles over a valid/ready stream. It walks the covered tiles in row-major order and makes one list write per clock. The input stays stalled until the last covered tile has been written. In the read phase the input is closed. A consumer then picks a tile and a slot and receives that tile's fill count and the stored identifier. Entries come back in the order the triangles were submitted.

When a list is already full, the unit drops the write and raises a sticky overflow flag, which tells software to split the pass. A clear pulse empties every list and drops the flag, taking one cycle per tile.

Top module: `tile_binner`

## Requirements
- R1: After reset every tile's fill count reads 0, `overflow` is low, and `in_ready` is high while `phase_read` is low.
- R2: An accepted, non-culled triangle is appended to every tile whose pixel square intersects the clamped integer bounding box of its three vertices. Tile column is x >> log2(TILE_PX), tile row is y >> log2(TILE_PX), and the tile number is row * TILES_X + column.
- R3: Vertex coordinates are signed and are clamped to the range 0..AREA_W-1 (x) and 0..AREA_H-1 (y). A box lying wholly outside the render area writes no list.
- R4: A triangle with `in_culled` high is accepted but written to no list, and `in_ready` returns high on the next cycle.
- R5: Within one tile's list, slot 0 holds the oldest surviving entry, and entries follow submission order.
- R6: After a triangle covering N tiles is accepted, `in_ready` stays low for exactly N cycles, one list write per cycle, with tiles visited row-major.
- R7: A write to a list that already holds BIN_DEPTH entries is dropped. The count stays at BIN_DEPTH, and `overflow` goes high and stays high until a clear.
- R8: While `phase_read` is high, `in_ready` is low. `rd_count` and `rd_data` show the fill count of `rd_tile` and the entry at `rd_slot` one clock after those inputs are presented.
- R9: A `clear` pulse given while no fan-out is in progress zeroes every fill count and `overflow`. `in_ready` is low for exactly TILES_X * TILES_Y cycles after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_read | input | 1 | 0 = accept triangles, 1 = serve list reads |
| clear | input | 1 | Empties all lists; ignored during a fan-out |
| in_valid | input | 1 | Triangle present on the input |
| in_ready | output | 1 | Unit can take a triangle this cycle |
| in_id | input | ID_W | Triangle identifier stored in lists |
| in_culled | input | 1 | Triangle was rejected upstream |
| in_x0 | input | COORD_W | Vertex 0 x, signed pixels |
| in_y0 | input | COORD_W | Vertex 0 y, signed pixels |
| in_x1 | input | COORD_W | Vertex 1 x, signed pixels |
| in_y1 | input | COORD_W | Vertex 1 y, signed pixels |
| in_x2 | input | COORD_W | Vertex 2 x, signed pixels |
| in_y2 | input | COORD_W | Vertex 2 y, signed pixels |
| rd_tile | input | TIDX_W | Tile number to read |
| rd_slot | input | SLOT_W | Entry position within the tile list |
| rd_count | output | CNT_W | Fill count of the selected tile |
| rd_data | output | ID_W | Identifier at the selected slot |
| overflow | output | 1 | Sticky: some list write was dropped |

## Verification
Small triangles that sit inside one tile confirm the column, row and index arithmetic. A triangle stretched past all four edges of the area checks clamping and the longest fan-out. Triangles placed wholly off-screen and triangles marked culled must leave every list untouched, and a correct stall of zero cycles separates these cases from an accepted triangle that was written anywhere. A batch of pseudo-random triangles near the edges, with overlapping covers, is compared list by list against an arithmetic model, which exposes ordering and indexing errors. A burst aimed at one tile then separates a correct drop-at-full from wraparound or overwrite, and a final clear shows that counts and the flag return to zero after the expected stall.

// File: rtl/tbin_pkg.sv
package tbin_pkg;

    // Width of a tile coordinate along one axis (up to 256 tiles per axis).
    localparam int TC_W = 8;

    typedef logic [TC_W-1:0] tcoord_t;

    // Inclusive range of covered tiles.
    typedef struct packed {
        tcoord_t x0;
        tcoord_t x1;
        tcoord_t y0;
        tcoord_t y1;
    } tile_box_t;

    typedef enum logic [0:0] {
        WK_IDLE = 1'b0,
        WK_WALK = 1'b1
    } walk_st_t;

    function automatic int tile_shift(input int px);
        return $clog2(px);
    endfunction

    function automatic int tiles_along(input int span, input int px);
        return (span + px - 1) / px;
    endfunction

endpackage

// File: rtl/tbin_bbox.sv
module tbin_bbox
    import tbin_pkg::*;
#(
    parameter int COORD_W = 12,
    parameter int AREA_W  = 128,
    parameter int AREA_H  = 64,
    parameter int TILE_PX = 16
) (
    input  logic signed [COORD_W-1:0] x0,
    input  logic signed [COORD_W-1:0] y0,
    input  logic signed [COORD_W-1:0] x1,
    input  logic signed [COORD_W-1:0] y1,
    input  logic signed [COORD_W-1:0] x2,
    input  logic signed [COORD_W-1:0] y2,
    output tile_box_t                 box,
    output logic                      hit
);
    localparam int SH = tile_shift(TILE_PX);
    localparam logic signed [COORD_W-1:0] XLIM = COORD_W'(AREA_W - 1);
    localparam logic signed [COORD_W-1:0] YLIM = COORD_W'(AREA_H - 1);

    logic signed [COORD_W-1:0] xmn, xmx, ymn, ymx;
    logic signed [COORD_W-1:0] cxmn, cxmx, cymn, cymx;

    always_comb begin
        xmn = x0;
        if (x1 < xmn) xmn = x1;
        if (x2 < xmn) xmn = x2;
        xmx = x0;
        if (x1 > xmx) xmx = x1;
        if (x2 > xmx) xmx = x2;
        ymn = y0;
        if (y1 < ymn) ymn = y1;
        if (y2 < ymn) ymn = y2;
        ymx = y0;
        if (y1 > ymx) ymx = y1;
        if (y2 > ymx) ymx = y2;

        hit = !((xmx < 0) || (ymx < 0) || (xmn > XLIM) || (ymn > YLIM));

        cxmn = (xmn < 0)    ? '0   : xmn;
        cxmx = (xmx > XLIM) ? XLIM : xmx;
        cymn = (ymn < 0)    ? '0   : ymn;
        cymx = (ymx > YLIM) ? YLIM : ymx;

        box.x0 = tcoord_t'($unsigned(cxmn) >> SH);
        box.x1 = tcoord_t'($unsigned(cxmx) >> SH);
        box.y0 = tcoord_t'($unsigned(cymn) >> SH);
        box.y1 = tcoord_t'($unsigned(cymx) >> SH);
    end

endmodule

// File: rtl/tbin_walker.sv
module tbin_walker
    import tbin_pkg::*;
#(
    parameter int ID_W    = 8,
    parameter int TILES_X = 8,
    parameter int TIDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phase_read,
    input  logic              blocked,
    input  logic              in_valid,
    input  logic              in_culled,
    input  logic [ID_W-1:0]   in_id,
    input  tile_box_t         box,
    input  logic              hit,
    output logic              in_ready,
    output logic              busy,
    output logic              wr_en,
    output logic [TIDX_W-1:0] wr_tile,
    output logic [ID_W-1:0]   wr_id
);
    walk_st_t  st;
    tile_box_t lim;
    tcoord_t   cur_x, cur_y;
    logic      last_tile;

    assign in_ready  = (st == WK_IDLE) && !phase_read && !blocked;
    assign busy      = (st == WK_WALK);
    assign wr_en     = (st == WK_WALK);
    assign wr_tile   = TIDX_W'(int'(cur_y) * TILES_X + int'(cur_x));
    assign last_tile = (cur_x == lim.x1) && (cur_y == lim.y1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= WK_IDLE;
            lim   <= '0;
            cur_x <= '0;
            cur_y <= '0;
            wr_id <= '0;
        end else begin
            case (st)
                WK_IDLE: begin
                    if (in_valid && in_ready && !in_culled && hit) begin
                        st    <= WK_WALK;
                        lim   <= box;
                        cur_x <= box.x0;
                        cur_y <= box.y0;
                        wr_id <= in_id;
                    end
                end
                WK_WALK: begin
                    if (last_tile) begin
                        st <= WK_IDLE;
                    end else if (cur_x == lim.x1) begin
                        cur_x <= lim.x0;
                        cur_y <= cur_y + 1'b1;
                    end else begin
                        cur_x <= cur_x + 1'b1;
                    end
                end
                default: st <= WK_IDLE;
            endcase
        end
    end

    AST_TILE_IN_BOX: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (cur_x >= lim.x0 && cur_x <= lim.x1 &&
                   cur_y >= lim.y0 && cur_y <= lim.y1)); // R2

    AST_ROW_MAJOR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en) && cur_y == $past(cur_y))
            |-> (cur_x == $past(cur_x) + tcoord_t'(1))); // R6

endmodule

// File: rtl/tbin_store.sv
module tbin_store #(
    parameter int ID_W      = 8,
    parameter int NUM_TILES = 32,
    parameter int BIN_DEPTH = 16,
    parameter int TIDX_W    = 5,
    parameter int SLOT_W    = 4,
    parameter int CNT_W     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              walk_busy,
    input  logic              wr_en,
    input  logic [TIDX_W-1:0] wr_tile,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [TIDX_W-1:0] rd_tile,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [CNT_W-1:0]  rd_count,
    output logic [ID_W-1:0]   rd_data,
    output logic              clr_busy,
    output logic              overflow
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BIN_DEPTH);

    logic [ID_W-1:0]   mem [NUM_TILES][BIN_DEPTH];
    logic [CNT_W-1:0]  cnt [NUM_TILES];
    logic [TIDX_W-1:0] clr_idx;
    logic              clr_start;
    logic              wr_full;

    assign clr_start = clear && !walk_busy && !clr_busy;
    assign wr_full   = (cnt[wr_tile] == FULL);

    // Fill counts, clear sweep and overflow flag.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < NUM_TILES; t++) cnt[t] <= '0;
            clr_busy <= 1'b0;
            clr_idx  <= '0;
            overflow <= 1'b0;
        end else if (clr_start) begin
            clr_busy <= 1'b1;
            clr_idx  <= '0;
            overflow <= 1'b0;
        end else if (clr_busy) begin
            cnt[clr_idx] <= '0;
            if (clr_idx == TIDX_W'(NUM_TILES - 1)) clr_busy <= 1'b0;
            else                                   clr_idx  <= clr_idx + 1'b1;
        end else if (wr_en) begin
            if (wr_full) overflow     <= 1'b1;
            else         cnt[wr_tile] <= cnt[wr_tile] + 1'b1;
        end
    end

    // List storage: no reset, only written below the fill count.
    always_ff @(posedge clk) begin
        if (wr_en && !clr_busy && !wr_full)
            mem[wr_tile][SLOT_W'(cnt[wr_tile])] <= wr_id;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_count <= '0;
            rd_data  <= '0;
        end else begin
            rd_count <= cnt[rd_tile];
            rd_data  <= mem[rd_tile][rd_slot];
        end
    end

    AST_NO_WRITE_DURING_CLEAR: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !clr_busy); // R9

    AST_FULL_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_full && !clr_start) |=> overflow); // R7

    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overflow && !clr_start) |=> overflow); // R7

endmodule

// File: rtl/tile_binner.sv
module tile_binner
    import tbin_pkg::*;
#(
    parameter int TILE_PX   = 16,
    parameter int AREA_W    = 128,
    parameter int AREA_H    = 64,
    parameter int BIN_DEPTH = 16,
    parameter int ID_W      = 8,
    parameter int COORD_W   = 12,
    localparam int TILES_X   = tiles_along(AREA_W, TILE_PX),
    localparam int TILES_Y   = tiles_along(AREA_H, TILE_PX),
    localparam int NUM_TILES = TILES_X * TILES_Y,
    localparam int TIDX_W    = (NUM_TILES > 1) ? $clog2(NUM_TILES) : 1,
    localparam int SLOT_W    = (BIN_DEPTH > 1) ? $clog2(BIN_DEPTH) : 1,
    localparam int CNT_W     = $clog2(BIN_DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      phase_read,
    input  logic                      clear,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [ID_W-1:0]           in_id,
    input  logic                      in_culled,
    input  logic signed [COORD_W-1:0] in_x0,
    input  logic signed [COORD_W-1:0] in_y0,
    input  logic signed [COORD_W-1:0] in_x1,
    input  logic signed [COORD_W-1:0] in_y1,
    input  logic signed [COORD_W-1:0] in_x2,
    input  logic signed [COORD_W-1:0] in_y2,
    input  logic [TIDX_W-1:0]         rd_tile,
    input  logic [SLOT_W-1:0]         rd_slot,
    output logic [CNT_W-1:0]          rd_count,
    output logic [ID_W-1:0]           rd_data,
    output logic                      overflow
);
    tile_box_t         box;
    logic              hit;
    logic              walk_busy;
    logic              clr_busy;
    logic              wr_en;
    logic [TIDX_W-1:0] wr_tile;
    logic [ID_W-1:0]   wr_id;

    tbin_bbox #(
        .COORD_W(COORD_W), .AREA_W(AREA_W), .AREA_H(AREA_H), .TILE_PX(TILE_PX)
    ) u_bbox (
        .x0(in_x0), .y0(in_y0), .x1(in_x1), .y1(in_y1), .x2(in_x2), .y2(in_y2),
        .box(box), .hit(hit)
    );

    tbin_walker #(
        .ID_W(ID_W), .TILES_X(TILES_X), .TIDX_W(TIDX_W)
    ) u_walker (
        .clk(clk), .rst(rst), .phase_read(phase_read),
        .blocked(clr_busy || clear),
        .in_valid(in_valid), .in_culled(in_culled), .in_id(in_id),
        .box(box), .hit(hit),
        .in_ready(in_ready), .busy(walk_busy),
        .wr_en(wr_en), .wr_tile(wr_tile), .wr_id(wr_id)
    );

    tbin_store #(
        .ID_W(ID_W), .NUM_TILES(NUM_TILES), .BIN_DEPTH(BIN_DEPTH),
        .TIDX_W(TIDX_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
    ) u_store (
        .clk(clk), .rst(rst), .clear(clear), .walk_busy(walk_busy),
        .wr_en(wr_en), .wr_tile(wr_tile), .wr_id(wr_id),
        .rd_tile(rd_tile), .rd_slot(rd_slot),
        .rd_count(rd_count), .rd_data(rd_data),
        .clr_busy(clr_busy), .overflow(overflow)
    );

    AST_READ_PHASE_CLOSED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |-> !phase_read); // R8

endmodule

// File: tb/tile_binner_tb.sv
module tile_binner_tb;
    localparam int TP = 16, AW = 128, AH = 64, DEP = 16;
    localparam int TX = 8, TY = 4, NT = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic phase_read = 1'b0, clear = 1'b0, in_valid = 1'b0, in_culled = 1'b0;
    logic in_ready, overflow;
    logic [7:0] in_id = '0;
    logic signed [11:0] in_x0 = '0, in_y0 = '0, in_x1 = '0, in_y1 = '0, in_x2 = '0, in_y2 = '0;
    logic [4:0] rd_tile = '0;
    logic [3:0] rd_slot = '0;
    logic [4:0] rd_count;
    logic [7:0] rd_data;

    int nchk = 0, nfail = 0;
    int exp_cnt [NT];
    int exp_id  [NT][DEP];
    bit exp_ovf = 1'b0;
    int next_id = 1;

    always #5 clk = ~clk;

    tile_binner #(.TILE_PX(TP), .AREA_W(AW), .AREA_H(AH), .BIN_DEPTH(DEP),
                  .ID_W(8), .COORD_W(12)) u_dut (
        .clk(clk), .rst(rst), .phase_read(phase_read), .clear(clear),
        .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id), .in_culled(in_culled),
        .in_x0(in_x0), .in_y0(in_y0), .in_x1(in_x1), .in_y1(in_y1),
        .in_x2(in_x2), .in_y2(in_y2), .rd_tile(rd_tile), .rd_slot(rd_slot),
        .rd_count(rd_count), .rd_data(rd_data), .overflow(overflow));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int mn3(input int a, input int b, input int c);
        int m = a;
        if (b < m) m = b;
        if (c < m) m = c;
        return m;
    endfunction

    function automatic int mx3(input int a, input int b, input int c);
        int m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

    // Reference model: returns number of tiles covered (walk length).
    function automatic int model(input int id, input int xa, input int ya, input int xb,
                                 input int yb, input int xc, input int yc, input bit cull);
        int x0 = mn3(xa, xb, xc), x1 = mx3(xa, xb, xc);
        int y0 = mn3(ya, yb, yc), y1 = mx3(ya, yb, yc);
        int n = 0;
        if (cull) return 0;
        if (x1 < 0 || y1 < 0 || x0 > AW - 1 || y0 > AH - 1) return 0;
        if (x0 < 0) x0 = 0;
        if (y0 < 0) y0 = 0;
        if (x1 > AW - 1) x1 = AW - 1;
        if (y1 > AH - 1) y1 = AH - 1;
        for (int ty = y0 / TP; ty <= y1 / TP; ty++) begin
            for (int tx = x0 / TP; tx <= x1 / TP; tx++) begin
                int t = ty * TX + tx;
                n++;
                if (exp_cnt[t] == DEP) exp_ovf = 1'b1;
                else begin
                    exp_id[t][exp_cnt[t]] = id;
                    exp_cnt[t]++;
                end
            end
        end
        return n;
    endfunction

    // Send one triangle, return the number of stall cycles after acceptance.
    task automatic send(input int xa, input int ya, input int xb, input int yb,
                        input int xc, input int yc, input bit cull, output int stall,
                        output int expn);
        int id = next_id % 256;
        next_id++;
        in_id = 8'(id);
        in_x0 = 12'(xa); in_y0 = 12'(ya); in_x1 = 12'(xb);
        in_y1 = 12'(yb); in_x2 = 12'(xc); in_y2 = 12'(yc);
        in_culled = cull;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        expn = model(id, xa, ya, xb, yb, xc, yc, cull);
        stall = 0;
        while (!in_ready) begin
            stall++;
            @(negedge clk);
        end
    endtask

    task automatic rd(input int t, input int s);
        rd_tile = 5'(t);
        rd_slot = 4'(s);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic verify(input string tag);
        phase_read = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b0, {"R8 ready low in read phase ", tag}, int'(in_ready), 0);
        for (int t = 0; t < NT; t++) begin
            rd(t, 0);
            chk(int'(rd_count) == exp_cnt[t], {"R2 count ", tag}, int'(rd_count), exp_cnt[t]);
            for (int s = 0; s < exp_cnt[t]; s++) begin
                rd(t, s);
                chk(int'(rd_data) == exp_id[t][s], {"R5 entry ", tag}, int'(rd_data), exp_id[t][s]);
            end
        end
        chk(overflow == exp_ovf, {"R7 overflow ", tag}, int'(overflow), int'(exp_ovf));
        phase_read = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int st, en;
        for (int t = 0; t < NT; t++) exp_cnt[t] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
        chk(overflow == 1'b0, "R1 overflow after reset", int'(overflow), 0);
        verify("R1 reset");

        // R2 single tile: tile (2,1) = 10
        send(40, 20, 44, 30, 35, 18, 1'b0, st, en);
        chk(st == 1 && en == 1, "R6 single tile stall", st, 1);
        // R2 3x2 tile box
        send(10, 10, 45, 12, 20, 25, 1'b0, st, en);
        chk(st == en && en == 6, "R6 six tile stall", st, en);
        // R4 culled triangle
        send(0, 0, 127, 63, 60, 30, 1'b1, st, en);
        chk(st == 0, "R4 culled no stall", st, 0);
        // R3 wholly off area
        send(-30, -20, -5, -1, -10, -40, 1'b0, st, en);
        chk(st == 0, "R3 offscreen no stall", st, 0);
        send(130, 10, 200, 20, 150, 60, 1'b0, st, en);
        chk(st == 0, "R3 right of area no stall", st, 0);
        // R3 spans all edges: covers all tiles
        send(-50, -50, 300, 10, 20, 200, 1'b0, st, en);
        chk(st == NT && en == NT, "R3 R6 full cover stall", st, NT);
        verify("directed");

        // Random triangles near and across the edges
        for (int i = 0; i < 60; i++) begin
            int bx = $urandom_range(0, 200) - 40;
            int by = $urandom_range(0, 130) - 35;
            send(bx, by, bx + $urandom_range(0, 40), by + $urandom_range(0, 30),
                 bx + $urandom_range(0, 25) - 10, by + $urandom_range(0, 20),
                 ($urandom_range(0, 7) == 0), st, en);
            chk(st == en, "R6 random stall", st, en);
        end
        verify("random");

        // R9 clear
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        st = 0;
        while (!in_ready) begin
            st++;
            @(negedge clk);
        end
        chk(st == NT, "R9 clear stall", st, NT);
        for (int t = 0; t < NT; t++) exp_cnt[t] = 0;
        exp_ovf = 1'b0;
        verify("R9 after clear");

        // R7 overflow in tile 31 (x 112..127, y 48..63)
        for (int i = 0; i < DEP + 3; i++) begin
            send(115, 50, 120, 55, 118, 60, 1'b0, st, en);
        end
        chk(overflow == 1'b1, "R7 flag set", int'(overflow), 1);
        send(3, 3, 5, 5, 4, 6, 1'b0, st, en);
        chk(overflow == 1'b1, "R7 flag sticky", int'(overflow), 1);
        verify("R7 overflow");

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule